// File: doc/BRIEF.md
# Isochronous stream source multiplexer

This block takes one of two video word streams, raw sensor pixels or compressed encoder output, and holds the chosen stream in an elastic buffer of 8 KB by default (2048 words of 32 bits). It meters the buffer out to an isochronous link interface as a fixed-size block once per bus cycle. A host command starts capture, and a stop command ends it. The data path needs no processor. The processor only sets the source and the per-cycle quota while the block is stopped.

A strobe marks the start of each isochronous bus cycle. The block decides at that strobe whether the buffer holds a full payload. If it does, the block emits exactly one payload, one word per clock, with no backpressure. If it does not, the block sends nothing for that cycle and counts an underrun.

The controller has three states:
- `ST_IDLE`: stopped. The buffer is held empty and the configuration is sampled every clock.
- `ST_WAIT`: streaming, waiting for a cycle strobe.
- `ST_SEND`: emitting the payload.

The transitions are:
- start: `ST_IDLE` to `ST_WAIT` on a start command.
- launch: `ST_WAIT` to `ST_SEND` on a strobe when the buffer holds at least one quota.
- starve: `ST_WAIT` stays in `ST_WAIT` on a strobe when the buffer is short, and the underrun counter advances.
- halt: `ST_WAIT` to `ST_IDLE` on a strobe after a stop was requested.
- done: `ST_SEND` to `ST_WAIT` after the last word of the payload.

Top module: `iso_stream_mux`

## Requirements
- R1: After reset the block is stopped. `streaming`, `iso_valid`, `iso_last` and `overflow` are 0, and `underrun_count` is 0.
- R2: `cfg_src_sel` chooses the source: 0 is raw (`raw_*`) and 1 is compressed (`enc_*`). `cfg_quota` gives the payload in words. Both are taken only while the block is stopped. The values present at the clock of the start command hold until the block stops again, and changes made while streaming have no effect.
- R3: Words from the selected source are stored only while `streaming` is 1. `streaming` rises on the clock after `cmd_start`. Valid words presented while the block is stopped are discarded.
- R4: If the buffer holds at least the quota (quota nonzero) at a clock where `cycle_start` is 1, the block emits exactly quota words. The words start on the next clock, come one per clock with `iso_valid` high, appear in arrival order, and carry `iso_last` high only on the final word.
- R5: If the buffer holds fewer words than a nonzero quota at a cycle strobe, no word is emitted for that cycle. `underrun_count` rises by one and saturates at its maximum value.
- R6: A quota of 0 emits nothing and counts no underrun.
- R7: A valid word that arrives while the buffer is full is dropped, and the sticky `overflow` flag is set until reset. The words already stored are kept. Filling the buffer exactly does not set the flag.
- R8: `cmd_stop` takes effect at the next cycle strobe. A payload already under way completes in full. The strobe after the stop emits nothing and returns the block to stopped, and any words left in the buffer are discarded.
- R9: A `cycle_start` that arrives while a payload is being emitted is ignored. The payload continues unchanged and no underrun is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_start | input | 1 | Start streaming (one-clock pulse) |
| cmd_stop | input | 1 | Request stop at the next cycle strobe |
| cfg_src_sel | input | 1 | Source select: 0 raw, 1 compressed |
| cfg_quota | input | QW | Payload size in words per bus cycle |
| raw_valid | input | 1 | Raw word present |
| raw_data | input | W | Raw word |
| enc_valid | input | 1 | Compressed word present |
| enc_data | input | W | Compressed word |
| cycle_start | input | 1 | Isochronous cycle-start strobe |
| iso_valid | output | 1 | Payload word valid |
| iso_data | output | W | Payload word |
| iso_last | output | 1 | Final word of the payload |
| streaming | output | 1 | Block is streaming |
| underrun_count | output | UNDER_W | Saturating count of starved cycles |
| overflow | output | 1 | Sticky flag for a dropped input word |

## Verification
The bench builds the block with a 16-word buffer and a 4-bit underrun counter. The small buffer lets a few dozen writes reach the exact-full boundary, a full-depth payload and dropped input. The narrow counter reaches its saturation value after a short run of starved cycles. The raw and compressed inputs carry different word patterns on every clock, so each emitted word shows which source was latched and in what order the words were stored.

// File: rtl/iso_stream_pkg.sv
package iso_stream_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_SEND = 2'd2
    } iso_state_e;

    typedef enum logic {
        SRC_RAW = 1'b0,
        SRC_ENC = 1'b1
    } iso_src_e;

endpackage

// File: rtl/iso_word_fifo.sv
module iso_word_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          full
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_wr;
    logic          do_rd;

    assign full    = (count == FULL_CNT);
    assign do_wr   = wr_en && !full && !flush;
    assign do_rd   = rd_en && (count != '0) && !flush;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + AW'(1);
            if (do_rd) rd_ptr <= rd_ptr + AW'(1);
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R7: occupancy never exceeds the buffer depth
    p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R7: a full buffer stays full until something is read or flushed
    p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en && !flush) |=> full);

endmodule

// File: rtl/iso_src_select.sv
module iso_src_select
    import iso_stream_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         streaming,
    input  iso_src_e     src,
    input  logic         raw_valid,
    input  logic [W-1:0] raw_data,
    input  logic         enc_valid,
    input  logic [W-1:0] enc_data,
    input  logic         fifo_full,
    output logic         wr_en,
    output logic [W-1:0] wr_data,
    output logic         overflow
);
    logic sel_valid;

    always_comb begin
        unique case (src)
            SRC_RAW: begin
                sel_valid = raw_valid;
                wr_data   = raw_data;
            end
            SRC_ENC: begin
                sel_valid = enc_valid;
                wr_data   = enc_data;
            end
            default: begin
                sel_valid = 1'b0;
                wr_data   = '0;
            end
        endcase
    end

    assign wr_en = streaming && sel_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (wr_en && fifo_full) begin
            overflow <= 1'b1;
        end
    end

    // R7: the dropped-word flag never clears once set
    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R3: no word reaches the buffer while stopped
    p_idle_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !streaming |-> !wr_en);

endmodule

// File: rtl/iso_cycle_fsm.sv
module iso_cycle_fsm
    import iso_stream_pkg::*;
#(
    parameter int QW      = 12,
    parameter int UNDER_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic               cfg_src_sel,
    input  logic [QW-1:0]      cfg_quota,
    input  logic               cycle_start,
    input  logic [QW-1:0]      fifo_count,
    output iso_src_e           src,
    output logic               streaming,
    output logic               flush,
    output logic               rd_en,
    output logic               iso_valid,
    output logic               iso_last,
    output logic [UNDER_W-1:0] underrun_count
);
    localparam logic [UNDER_W-1:0] UNDER_MAX = {UNDER_W{1'b1}};

    iso_state_e         state_q, state_d;
    iso_src_e           src_q, src_d;
    logic [QW-1:0]      quota_q, quota_d;
    logic [QW-1:0]      remain_q, remain_d;
    logic               stop_q, stop_d;
    logic [UNDER_W-1:0] under_q, under_d;

    always_comb begin
        state_d  = state_q;
        src_d    = src_q;
        quota_d  = quota_q;
        remain_d = remain_q;
        stop_d   = stop_q;
        under_d  = under_q;
        if (state_q != ST_IDLE && cmd_stop) begin
            stop_d = 1'b1;
        end
        unique case (state_q)
            ST_IDLE: begin
                src_d   = iso_src_e'(cfg_src_sel);
                quota_d = cfg_quota;
                stop_d  = 1'b0;
                if (cmd_start) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (cycle_start) begin
                    if (stop_q) begin
                        state_d = ST_IDLE;
                        stop_d  = 1'b0;
                    end else if (quota_q != '0) begin
                        if (fifo_count >= quota_q) begin
                            state_d  = ST_SEND;
                            remain_d = quota_q;
                        end else if (under_q != UNDER_MAX) begin
                            under_d = under_q + UNDER_W'(1);
                        end
                    end
                end
            end
            ST_SEND: begin
                remain_d = remain_q - QW'(1);
                if (remain_q == QW'(1)) state_d = ST_WAIT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            src_q    <= SRC_RAW;
            quota_q  <= '0;
            remain_q <= '0;
            stop_q   <= 1'b0;
            under_q  <= '0;
        end else begin
            state_q  <= state_d;
            src_q    <= src_d;
            quota_q  <= quota_d;
            remain_q <= remain_d;
            stop_q   <= stop_d;
            under_q  <= under_d;
        end
    end

    always_comb begin
        streaming      = (state_q != ST_IDLE);
        flush          = (state_q == ST_IDLE);
        iso_valid      = (state_q == ST_SEND);
        rd_en          = (state_q == ST_SEND);
        iso_last       = (state_q == ST_SEND) && (remain_q == QW'(1));
        src            = src_q;
        underrun_count = under_q;
    end

    // R2: source and quota hold still for the whole streaming session
    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> ($stable(src_q) && $stable(quota_q)));

    // R4: a payload word is never taken from an empty buffer
    p_no_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iso_valid |-> (fifo_count != '0));

    // R5: a starved cycle emits nothing and advances the counter
    p_underrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cycle_start && !stop_q && quota_q != '0 &&
         fifo_count < quota_q && under_q != UNDER_MAX)
        |=> (!iso_valid && under_q == $past(under_q) + UNDER_W'(1)));

    // R6: a zero quota never launches a payload
    p_zero_quota_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && quota_q == '0) |=> !iso_valid);

    // R8: a pending stop ends streaming at the strobe, with no output
    p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && cycle_start && stop_q) |=> (!streaming && !iso_valid));

    // R9: a payload in progress is not cut short by a strobe
    p_burst_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_valid && !iso_last) |=> iso_valid);

endmodule

// File: rtl/iso_stream_mux.sv
module iso_stream_mux
    import iso_stream_pkg::*;
#(
    parameter int W       = 32,
    parameter int DEPTH   = 2048,
    parameter int UNDER_W = 16,
    localparam int QW     = $clog2(DEPTH) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_start,
    input  logic               cmd_stop,
    input  logic               cfg_src_sel,
    input  logic [QW-1:0]      cfg_quota,
    input  logic               raw_valid,
    input  logic [W-1:0]       raw_data,
    input  logic               enc_valid,
    input  logic [W-1:0]       enc_data,
    input  logic               cycle_start,
    output logic               iso_valid,
    output logic [W-1:0]       iso_data,
    output logic               iso_last,
    output logic               streaming,
    output logic [UNDER_W-1:0] underrun_count,
    output logic               overflow
);
    iso_src_e      src;
    logic          flush;
    logic          rd_en;
    logic          wr_en;
    logic [W-1:0]  wr_data;
    logic [QW-1:0] fifo_count;
    logic          fifo_full;

    iso_cycle_fsm #(
        .QW      (QW),
        .UNDER_W (UNDER_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_stop       (cmd_stop),
        .cfg_src_sel    (cfg_src_sel),
        .cfg_quota      (cfg_quota),
        .cycle_start    (cycle_start),
        .fifo_count     (fifo_count),
        .src            (src),
        .streaming      (streaming),
        .flush          (flush),
        .rd_en          (rd_en),
        .iso_valid      (iso_valid),
        .iso_last       (iso_last),
        .underrun_count (underrun_count)
    );

    iso_src_select #(
        .W (W)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .streaming (streaming),
        .src       (src),
        .raw_valid (raw_valid),
        .raw_data  (raw_data),
        .enc_valid (enc_valid),
        .enc_data  (enc_data),
        .fifo_full (fifo_full),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .overflow  (overflow)
    );

    iso_word_fifo #(
        .W     (W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (iso_data),
        .count   (fifo_count),
        .full    (fifo_full)
    );

endmodule

// File: tb/sim_iso_stream_mux.sv
module sim_iso_stream_mux;
    localparam int W       = 32;
    localparam int DEPTH   = 16;
    localparam int UNDER_W = 4;
    localparam int QW      = $clog2(DEPTH) + 1;
    localparam logic [W-1:0] RAW_BASE = 32'hA000_0000;
    localparam logic [W-1:0] ENC_BASE = 32'hE000_0000;
    localparam int NV = 6;
    // each row: source, quota, words pushed before the strobe
    localparam int VEC [NV][3] = '{
        '{0, 4, 4}, '{1, 3, 5}, '{0, 5, 2}, '{1, 1, 1}, '{1, 0, 3}, '{0, 16, 16}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_start = 1'b0;
    logic               cmd_stop = 1'b0;
    logic               cfg_src_sel = 1'b0;
    logic [QW-1:0]      cfg_quota = '0;
    logic               raw_valid = 1'b0;
    logic [W-1:0]       raw_data = '0;
    logic               enc_valid = 1'b0;
    logic [W-1:0]       enc_data = '0;
    logic               cycle_start = 1'b0;
    logic               iso_valid;
    logic [W-1:0]       iso_data;
    logic               iso_last;
    logic               streaming;
    logic [UNDER_W-1:0] underrun_count;
    logic               overflow;

    int checks = 0;
    int errors = 0;
    int exp_under = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    iso_stream_mux #(.W(W), .DEPTH(DEPTH), .UNDER_W(UNDER_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
        .cfg_src_sel(cfg_src_sel), .cfg_quota(cfg_quota),
        .raw_valid(raw_valid), .raw_data(raw_data),
        .enc_valid(enc_valid), .enc_data(enc_data),
        .cycle_start(cycle_start), .iso_valid(iso_valid), .iso_data(iso_data),
        .iso_last(iso_last), .streaming(streaming),
        .underrun_count(underrun_count), .overflow(overflow)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] word(int src, int idx);
        return (src != 0 ? ENC_BASE : RAW_BASE) + W'(idx);
    endfunction

    task automatic bump_under();
        if (exp_under < 15) exp_under++;
    endtask

    task automatic push(int n);
        for (int i = 0; i < n; i++) begin
            raw_valid = 1'b1; raw_data = word(0, i);
            enc_valid = 1'b1; enc_data = word(1, i);
            tick();
        end
        raw_valid = 1'b0;
        enc_valid = 1'b0;
    endtask

    task automatic strobe();
        cycle_start = 1'b1;
        tick();
        cycle_start = 1'b0;
    endtask

    task automatic start(int src, int q);
        cfg_src_sel = src[0];
        cfg_quota   = QW'(q);
        tick();
        cmd_start = 1'b1;
        tick();
        cmd_start = 1'b0;
    endtask

    task automatic stop_all();
        cmd_stop = 1'b1;
        tick();
        cmd_stop = 1'b0;
        strobe();
        chk("R8 stopped after strobe", W'(streaming), 0);
    endtask

    task automatic burst(string req, int src, int q);
        for (int j = 0; j < q; j++) begin
            chk(req, W'(iso_valid), 1);
            chk(req, iso_data, word(src, j));
            chk(req, W'(iso_last), W'(j == q - 1));
            tick();
        end
        chk(req, W'(iso_valid), 0);
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 streaming", W'(streaming), 0);
        chk("R1 iso_valid", W'(iso_valid), 0);
        chk("R1 iso_last", W'(iso_last), 0);
        chk("R1 overflow", W'(overflow), 0);
        chk("R1 underrun", W'(underrun_count), 0);

        // R3 words offered while stopped are discarded
        push(3);
        start(0, 1);
        chk("R3 streaming", W'(streaming), 1);
        strobe();
        chk("R3 idle data not kept", W'(iso_valid), 0);
        bump_under();
        chk("R5 underrun", W'(underrun_count), W'(exp_under));
        stop_all();

        // R4 R5 R6 vector table
        for (int v = 0; v < NV; v++) begin
            start(VEC[v][0], VEC[v][1]);
            push(VEC[v][2]);
            strobe();
            if (VEC[v][1] != 0 && VEC[v][2] >= VEC[v][1]) begin
                burst("R4 payload", VEC[v][0], VEC[v][1]);
            end else begin
                chk("R5 R6 no payload", W'(iso_valid), 0);
                if (VEC[v][1] != 0) bump_under();
            end
            chk("R5 R6 underrun", W'(underrun_count), W'(exp_under));
            stop_all();
        end
        chk("R7 exact fill no overflow", W'(overflow), 0);

        // R2 config changes while streaming are ignored
        start(0, 2);
        cfg_src_sel = 1'b1;
        cfg_quota   = QW'(1);
        push(2);
        strobe();
        burst("R2 config held", 0, 2);
        stop_all();

        // R7 overflow drops new words and keeps old ones
        start(1, 16);
        push(20);
        chk("R7 overflow set", W'(overflow), 1);
        strobe();
        burst("R7 first words kept", 1, 16);
        stop_all();
        chk("R7 overflow sticky", W'(overflow), 1);

        // R8 R9 stop and strobe during a payload
        start(0, 4);
        push(8);
        strobe();
        for (int j = 0; j < 4; j++) begin
            chk("R9 burst continues", W'(iso_valid), 1);
            chk("R9 burst data", iso_data, word(0, j));
            cycle_start = (j == 1);
            cmd_stop    = (j == 2);
            tick();
            cycle_start = 1'b0;
            cmd_stop    = 1'b0;
        end
        chk("R9 burst ends", W'(iso_valid), 0);
        chk("R9 no underrun", W'(underrun_count), W'(exp_under));
        chk("R8 still streaming", W'(streaming), 1);
        strobe();
        chk("R8 halt no output", W'(iso_valid), 0);
        chk("R8 halted", W'(streaming), 0);
        start(0, 1);
        strobe();
        chk("R8 leftovers discarded", W'(iso_valid), 0);
        bump_under();
        chk("R8 underrun after flush", W'(underrun_count), W'(exp_under));

        // R5 counter saturation
        for (int k = 0; k < 20; k++) begin
            strobe();
            bump_under();
        end
        chk("R5 saturated", W'(underrun_count), W'(exp_under));
        stop_all();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule